// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block steers an in-order five-stage pipeline: fetch, decode with register read, execute with branch resolution, memory access and writeback. Each cycle it looks at the source register numbers of the instructions in decode and execute, and at the destination, write enable and load flag of the three older pipeline registers. From these it chooses, for each execute operand, whether the value comes from the register file, the execute/memory register or the memory/writeback register. It also decides whether decode must wait, whether a bubble goes into execute, and whether the two youngest instructions are discarded.

A run-time input, `fwd_en`, picks the hazard policy. With forwarding off, a dependent instruction waits in decode until its producer reaches writeback. The register file writes early in the cycle and reads late, so writeback needs no bypass. With forwarding on, results are bypassed into execute, and only a load followed directly by a consumer costs one stall cycle. Branches are predicted not taken. When execute reports a taken branch or jump, the two younger instructions are flushed, which costs two cycles. A flush beats a stall.

A small state machine has two states. In `ST_RUN` the unit works normally. `ST_HALTED` is entered through the transition `RUN->HALTED`, taken on a clock edge where `wb_halt` is high. Nothing leaves this state except reset. The freeze output rises in the same cycle that `wb_halt` is seen and stays high until reset. An unused source operand is presented as register 0, which never causes a hazard.

Top module: `hzd_ctrl`

## Requirements
- R1: With `fwd_en` low, both `fwd_a` and `fwd_b` are 2'b00 (register file).
- R2: With `fwd_en` low, `stall` and `bubble` are high when `id_rs` or `id_rt` equals `ex_rd` with `ex_we` high, or equals `mem_rd` with `mem_we` high. A match only against `wb_rd` gives no stall.
- R3: With `fwd_en` high, an execute source equal to `mem_rd`, with `mem_we` high and `mem_ld` low, selects 2'b01 (execute/memory register).
- R4: With `fwd_en` high, an execute source equal to `wb_rd` with `wb_we` high selects 2'b10 (memory/writeback register), unless rule R3 applies, in which case 2'b01 wins.
- R5: With `fwd_en` high, `stall` and `bubble` are high only when `ex_ld` and `ex_we` are high and `ex_rd` equals `id_rs` or `id_rt`. A non-load producer in execute causes no stall.
- R6: Register 0 never causes a stall or a forward, whatever the enables.
- R7: When `ex_taken` is high (and the unit is not frozen), `flush` is high and `stall` and `bubble` are low. Forwarding selects keep their normal values.
- R8: When `wb_halt` is high, `freeze` is high in the same cycle. It stays high on every later cycle until reset. While `freeze` is high, `stall`, `bubble` and `flush` are low and both selects are 2'b00.
- R9: Reset returns the state machine to `ST_RUN`, so `freeze` is low after reset while `wb_halt` is low.
- R10: A destination whose write enable is low never causes a stall or a forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_en | input | 1 | Forwarding mode: 1 bypass, 0 stall-only |
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| ex_rs | input | 5 | First source register of the execute instruction |
| ex_rt | input | 5 | Second source register of the execute instruction |
| ex_rd | input | 5 | Destination in the decode/execute register |
| ex_we | input | 1 | Write enable in the decode/execute register |
| ex_ld | input | 1 | Load flag in the decode/execute register |
| mem_rd | input | 5 | Destination in the execute/memory register |
| mem_we | input | 1 | Write enable in the execute/memory register |
| mem_ld | input | 1 | Load flag in the execute/memory register |
| wb_rd | input | 5 | Destination in the memory/writeback register |
| wb_we | input | 1 | Write enable in the memory/writeback register |
| ex_taken | input | 1 | Branch or jump in execute is taken |
| wb_halt | input | 1 | Halt instruction is in writeback |
| fwd_a | output | 2 | Select for operand A: 00 regfile, 01 exec/mem, 10 mem/wb |
| fwd_b | output | 2 | Select for operand B, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |
| flush | output | 1 | Discard the fetch/decode and decode/execute contents |
| freeze | output | 1 | Hold every pipeline register after a halt |

## Verification
The hardest case to reach is a cycle where several rules compete. Examples are a load in execute that matches a decode source while a taken branch flushes, or a source that matches both older destinations while one of them is a load. Uniform random register numbers would almost never line up like this. The bench therefore draws register numbers from the range 0 to 3, so matches and register 0 appear often, and mixes random load, enable and branch flags with directed vectors for each priority clash. Halt stickiness is checked by holding `wb_halt` for one edge only, then driving stimulus that would otherwise stall or flush.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int REG_AW  = 5;
    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_EXMEM = 2'b01,
        FWD_MEMWB = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } hzd_state_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] src,
    input  logic          en,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_ld,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    output fwd_sel_e      sel
);
    localparam logic [AW-1:0] ZERO = '0;

    logic hit_mem;
    logic hit_wb;

    assign hit_mem = mem_we && !mem_ld && (mem_rd != ZERO) && (src == mem_rd);
    assign hit_wb  = wb_we && (wb_rd != ZERO) && (src == wb_rd);

    always_comb begin
        sel = FWD_RF;
        if (en) begin
            if (hit_mem)     sel = FWD_EXMEM;   // younger result wins
            else if (hit_wb) sel = FWD_MEMWB;
        end
    end
endmodule

// File: rtl/hzd_stall_det.sv
module hzd_stall_det
    import hzd_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          fwd_en,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_ld,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    output logic          stall_req
);
    localparam logic [AW-1:0] ZERO = '0;

    logic dep_ex;
    logic dep_mem;

    assign dep_ex  = ex_we && (ex_rd != ZERO) &&
                     ((id_rs == ex_rd) || (id_rt == ex_rd));
    assign dep_mem = mem_we && (mem_rd != ZERO) &&
                     ((id_rs == mem_rd) || (id_rt == mem_rd));

    always_comb begin
        if (fwd_en) stall_req = dep_ex && ex_ld;       // load-use only
        else        stall_req = dep_ex || dep_mem;     // wait for writeback
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd_en,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic [AW-1:0] ex_rs,
    input  logic [AW-1:0] ex_rt,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_ld,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic          mem_ld,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic          ex_taken,
    input  logic          wb_halt,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          stall,
    output logic          bubble,
    output logic          flush,
    output logic          freeze
);
    hzd_state_e state_q;
    hzd_state_e state_d;

    logic [AW-1:0] ex_src [NUM_SRC];
    fwd_sel_e      sel_raw [NUM_SRC];
    logic          stall_req;

    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
        hzd_fwd_sel #(.AW(AW)) u_sel (
            .src    (ex_src[g]),
            .en     (fwd_en),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .mem_ld (mem_ld),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel_raw[g])
        );
    end

    hzd_stall_det #(.AW(AW)) u_stall (
        .id_rs     (id_rs),
        .id_rt     (id_rt),
        .fwd_en    (fwd_en),
        .ex_rd     (ex_rd),
        .ex_we     (ex_we),
        .ex_ld     (ex_ld),
        .mem_rd    (mem_rd),
        .mem_we    (mem_we),
        .stall_req (stall_req)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        fwd_a   = FWD_RF;
        fwd_b   = FWD_RF;
        stall   = 1'b0;
        bubble  = 1'b0;
        flush   = 1'b0;
        freeze  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (wb_halt) begin
                    state_d = ST_HALTED;            // RUN->HALTED
                    freeze  = 1'b1;
                end else begin
                    fwd_a = sel_raw[0];
                    fwd_b = sel_raw[1];
                    if (ex_taken) begin
                        flush = 1'b1;               // flush beats stall
                    end else begin
                        stall  = stall_req;
                        bubble = stall_req;
                    end
                end
            end
            ST_HALTED: begin
                freeze = 1'b1;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    localparam logic [AW-1:0] RZ = '0;

    AST_OFF_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |-> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R1
    AST_EXMEM_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == 2'b01 || fwd_b == 2'b01) |-> !mem_ld); // R3
    AST_R0_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs == RZ) |-> (fwd_a == 2'b00)); // R6
    AST_NO_STALL_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stall && !bubble)); // R7
    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> freeze); // R8
    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (!stall && !flush && !bubble)); // R8
    AST_WE_LOW_NO_HAZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we && !mem_we) |-> !stall); // R10
endmodule

// File: tb/tb_hzd_ctrl.sv
`timescale 1ns/1ps
module tb_hzd_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_en = 1'b0;
    logic [4:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0;
    logic [4:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic ex_we = 1'b0, ex_ld = 1'b0, mem_we = 1'b0, mem_ld = 1'b0, wb_we = 1'b0;
    logic ex_taken = 1'b0, wb_halt = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic stall, bubble, flush, freeze;

    int n_run = 0;
    int n_fail = 0;
    bit halted_m = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hzd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
        .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_ld(mem_ld),
        .wb_rd(wb_rd), .wb_we(wb_we), .ex_taken(ex_taken), .wb_halt(wb_halt),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble),
        .flush(flush), .freeze(freeze)
    );

    function automatic logic [1:0] exp_sel(input logic [4:0] s);
        if (!fwd_en) return 2'b00;
        if (mem_we && !mem_ld && mem_rd != 0 && s == mem_rd) return 2'b01;
        if (wb_we && wb_rd != 0 && s == wb_rd) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [7:0] expected();
        logic dex, dmem, st;
        logic fz;
        fz   = halted_m || wb_halt;
        dex  = ex_we && ex_rd != 0 && (id_rs == ex_rd || id_rt == ex_rd);
        dmem = mem_we && mem_rd != 0 && (id_rs == mem_rd || id_rt == mem_rd);
        st   = fwd_en ? (dex && ex_ld) : (dex || dmem);
        if (fz) return 8'b0000_0001;
        if (ex_taken) return {exp_sel(ex_rs), exp_sel(ex_rt), 1'b0, 1'b0, 1'b1, 1'b0};
        return {exp_sel(ex_rs), exp_sel(ex_rt), st, st, 1'b0, 1'b0};
    endfunction

    task automatic step(input string tag);
        logic [7:0] act, exp_v;
        #1;
        act   = {fwd_a, fwd_b, stall, bubble, flush, freeze};
        exp_v = expected();
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got {fa,fb,st,bu,fl,fz}=%b expected %b", tag, act, exp_v);
        end
        @(posedge clk);
        if (rst_n && wb_halt) halted_m = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_in();
        {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
        {ex_we, ex_ld, mem_we, mem_ld, wb_we, ex_taken, wb_halt} = '0;
    endtask

    task automatic do_reset();
        clear_in();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        halted_m = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2025));
        @(negedge clk);
        do_reset();
        step("R9 reset idle");

        // R1: off mode, EX/MEM match -> no forward
        clear_in(); fwd_en = 0; ex_rs = 5'd3; mem_rd = 5'd3; mem_we = 1;
        step("R1 off no fwd");
        // R2: off mode, ID/EX match
        clear_in(); fwd_en = 0; id_rs = 5'd4; ex_rd = 5'd4; ex_we = 1;
        step("R2 off stall idex");
        clear_in(); fwd_en = 0; id_rt = 5'd6; mem_rd = 5'd6; mem_we = 1;
        step("R2 off stall exmem");
        clear_in(); fwd_en = 0; id_rs = 5'd7; wb_rd = 5'd7; wb_we = 1;
        step("R2 off wb no stall");
        // R3 / R4
        clear_in(); fwd_en = 1; ex_rs = 5'd2; mem_rd = 5'd2; mem_we = 1;
        step("R3 exmem fwd");
        clear_in(); fwd_en = 1; ex_rt = 5'd9; wb_rd = 5'd9; wb_we = 1;
        step("R4 memwb fwd");
        clear_in(); fwd_en = 1; ex_rs = 5'd5; mem_rd = 5'd5; mem_we = 1;
        wb_rd = 5'd5; wb_we = 1;
        step("R4 younger wins");
        clear_in(); fwd_en = 1; ex_rs = 5'd5; mem_rd = 5'd5; mem_we = 1; mem_ld = 1;
        wb_rd = 5'd5; wb_we = 1;
        step("R3 load in exmem not bypassed");
        // R5
        clear_in(); fwd_en = 1; id_rt = 5'd8; ex_rd = 5'd8; ex_we = 1; ex_ld = 1;
        step("R5 load-use stall");
        clear_in(); fwd_en = 1; id_rs = 5'd8; ex_rd = 5'd8; ex_we = 1;
        step("R5 alu no stall");
        // R6
        clear_in(); fwd_en = 0; ex_we = 1; mem_we = 1;
        step("R6 r0 off");
        clear_in(); fwd_en = 1; ex_we = 1; ex_ld = 1; mem_we = 1; wb_we = 1;
        step("R6 r0 on");
        // R10
        clear_in(); fwd_en = 0; id_rs = 5'd3; ex_rd = 5'd3; mem_rd = 5'd3;
        ex_rs = 5'd3; wb_rd = 5'd3;
        step("R10 we low off");
        fwd_en = 1; ex_ld = 1;
        step("R10 we low on");
        // R7
        clear_in(); fwd_en = 1; id_rs = 5'd4; ex_rd = 5'd4; ex_we = 1; ex_ld = 1;
        ex_taken = 1; ex_rs = 5'd2; mem_rd = 5'd2; mem_we = 1;
        step("R7 flush beats stall");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            fwd_en = 1'($urandom_range(1, 0));
            id_rs = 5'($urandom_range(3, 0)); id_rt = 5'($urandom_range(3, 0));
            ex_rs = 5'($urandom_range(3, 0)); ex_rt = 5'($urandom_range(3, 0));
            ex_rd = 5'($urandom_range(3, 0)); mem_rd = 5'($urandom_range(3, 0));
            wb_rd = 5'($urandom_range(3, 0));
            ex_we = 1'($urandom_range(1, 0)); mem_we = 1'($urandom_range(1, 0));
            wb_we = 1'($urandom_range(1, 0));
            ex_ld = ($urandom_range(3, 0) == 0); mem_ld = ($urandom_range(3, 0) == 0);
            ex_taken = ($urandom_range(6, 0) == 0);
            step("RND mix");
        end

        // R8: halt for one edge, then hazards that would otherwise show
        clear_in(); wb_halt = 1; fwd_en = 1; ex_taken = 1;
        step("R8 freeze same cycle");
        clear_in(); fwd_en = 0; id_rs = 5'd1; ex_rd = 5'd1; ex_we = 1;
        step("R8 sticky no stall");
        clear_in(); ex_taken = 1; fwd_en = 1; ex_rs = 5'd2; mem_rd = 5'd2; mem_we = 1;
        step("R8 sticky no flush");

        // R9: reset leaves halted state
        do_reset();
        step("R9 freeze cleared");
        clear_in(); fwd_en = 0; id_rs = 5'd1; ex_rd = 5'd1; ex_we = 1;
        step("R9 stall works after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule